// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles. It does not pass the words along a chain of flip-flops. It stores them in a two-port memory of 2^ADDR_W entries, and the stored words never move. Two address counters step through the memory once per clock. The write counter names the slot that takes the incoming word. The read counter names the slot whose word goes to the registered output.

After a synchronous reset the two counters sit at opposite ends of the memory. The read counter starts at the lowest slot and the write counter at the highest. From then on the output repeats the input with a latency of 2^ADDR_W − 1 clock edges. The read register accounts for one of these edges and the pointer gap for the rest.

A flag marks the point where the first word written after reset appears at the output. Before that point the output holds stale memory contents, which carry no meaning. Typical users are long pipeline-balancing delays, where a chain of registers this long would cost more area than a small memory.

Top module: `long_delay_line`

## Requirements
- R1: While reset is asserted at a clock edge, the output word is cleared to zero and the valid flag is low after that edge.
- R2: Let D = 2^ADDR_W and count clock edges from 0, starting at the first edge with reset low. Once the valid flag is high, the output word after edge k equals the input word sampled at edge k − (D − 1).
- R3: The valid flag stays low after each of edges 0 through D − 2 and is high after edge D − 1.
- R4: Once high, the valid flag stays high until reset is asserted again.
- R5: After reset the read address is all zeros and the write address is all ones. Each address rises by one on every edge with reset low, wrapping from D − 1 to 0. As a result, the write address always trails the read address by exactly one slot.
- R6: Asserting reset in the middle of a stream clears the valid flag and restarts the R3 sequence. No word written before the reset appears at the output while the flag is high.
- R7: No edge both writes and reads the same memory slot.
- R8: Every data bit is carried independently. Patterns of all zeros, all ones, walking ones and alternating bits come out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | DATA_W | Word taken in on every clock edge |
| dataOut | output | DATA_W | Delayed word, registered |
| outValid | output | 1 | High once the output carries words written since reset |

## Verification
A counting sequence gives every word a distinct value. A wrong latency therefore shows up as an offset of the exact size of the error, and a pointer that wraps badly shows up as a jump. Walking-one and alternating 0x55/0xAA words catch swapped or stuck data bits that a counter might hide. A hashed sequence run after a reset issued mid-stream shows whether old memory contents leak out once the flag rises again. Two depths are run side by side. The smallest depth, two entries with a latency of one edge, separates pointer-gap faults from read-register faults.

// File: rtl/ldl_pkg.sv
package ldl_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic wrEn;    // store the incoming word at the write address
    logic rdEn;    // fetch the word at the read address into the output register
    logic clrOut;  // clear the output register
  } ldl_strobe_t;

  // Number of edges between sampling a word and seeing it at the output
  function automatic int unsigned ldlLatency(input int unsigned addrW);
    return (32'd1 << addrW) - 32'd1;
  endfunction

endpackage

// File: rtl/ldl_ctrl.sv
module ldl_ctrl
  import ldl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output ldl_strobe_t       strobe,
  output logic              primed
);

  localparam logic [ADDR_W-1:0] LAST_SLOT  = '1;
  localparam logic [ADDR_W-1:0] FIRST_SLOT = '0;

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic              primedQ;

  // Write counter: starts at the top slot, wraps naturally
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= LAST_SLOT;
    end else begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  // Read counter: starts at the bottom slot, wraps naturally
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= FIRST_SLOT;
    end else begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  // The first word written after reset sits in the top slot. It reaches the
  // output on the edge where the read counter first points there.
  always_ff @(posedge clk) begin
    if (rst) begin
      primedQ <= 1'b0;
    end else if (rdPtr == LAST_SLOT) begin
      primedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.wrEn   = !rst;
    strobe.rdEn   = !rst;
    strobe.clrOut = rst;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;
  assign primed = primedQ;

endmodule

// File: rtl/ldl_dpath.sv
module ldl_dpath
  import ldl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  ldl_strobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] outReg;

  // Write port: the memory holds no reset, its contents stay in place
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      store[wrAddr] <= dataIn;
    end
  end

  // Read port: registered. The addresses never match, so no bypass is needed.
  always_ff @(posedge clk) begin
    if (strobe.clrOut) begin
      outReg <= '0;
    end else if (strobe.rdEn) begin
      outReg <= store[rdAddr];
    end
  end

  assign dataOut = outReg;

endmodule

// File: rtl/long_delay_line.sv
module long_delay_line
  import ldl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outValid
);

  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  ldl_strobe_t       strobe;

  ldl_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobe (strobe),
    .primed (outValid)
  );

  ldl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk     (clk),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/ldl_chk.sv
module ldl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrEn,
  input logic              outValid
);

  logic rstQ;
  logic runQ;

  // rstQ: the previous edge was in reset. runQ: at least one edge ran out of reset.
  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) runQ <= 1'b0;
    else     runQ <= 1'b1;
  end

  // R1 / R5: state right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    rstQ |-> (rdAddr == '0 && wrAddr == '1 && !outValid));

  // R5: both counters advance by one per edge
  a_r5_rd_step: assert property (@(posedge clk) disable iff (rst)
    runQ |-> rdAddr == ADDR_W'($past(rdAddr) + 1'b1));

  a_r5_wr_step: assert property (@(posedge clk) disable iff (rst)
    runQ |-> wrAddr == ADDR_W'($past(wrAddr) + 1'b1));

  // R5: fixed one-slot gap between the counters
  a_r5_gap: assert property (@(posedge clk) disable iff (rst)
    wrAddr == ADDR_W'(rdAddr - 1'b1));

  // R7: never write and read the same slot together
  a_r7_no_collision: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> wrAddr != rdAddr);

  // R4: valid is sticky until reset
  a_r4_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid);

  // R3: valid rises on the edge that wraps the read counter back to zero
  a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> rdAddr == '0);

endmodule

bind long_delay_line ldl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wrAddr   (wrAddr),
  .rdAddr   (rdAddr),
  .wrEn     (strobe.wrEn),
  .outValid (outValid)
);

// File: tb/long_delay_line_tb_top.sv
module long_delay_line_tb_top;

  localparam int AW_BIG   = 3;
  localparam int AW_SMALL = 1;
  localparam int DW       = 8;
  localparam int D_BIG    = 1 << AW_BIG;
  localparam int D_SMALL  = 1 << AW_SMALL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] outBig, outSmall;
  logic          validBig, validSmall;

  int total = 0;
  int bad   = 0;
  int n     = 0;       // edges since reset release
  logic [DW-1:0] hist [0:1023];

  always #10 clk = ~clk;  // 50 MHz

  long_delay_line #(.ADDR_W(AW_BIG), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .dataIn(dIn), .dataOut(outBig), .outValid(validBig));

  long_delay_line #(.ADDR_W(AW_SMALL), .DATA_W(DW)) dut_small_i (
    .clk(clk), .rst(rst), .dataIn(dIn), .dataOut(outSmall), .outValid(validSmall));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (edge %0d)", req, act, exp, n);
    end
  endtask

  // Flag and data checks for one depth after edge n-1
  task automatic checkDepth(input string req, input int d,
                            input logic v, input logic [DW-1:0] q);
    check({"R3/R4 valid ", req}, int'(v), int'(n >= d));
    if (n >= d) check({"R2 data ", req}, int'(q), int'(hist[n - d]));
  endtask

  task automatic step(input logic [DW-1:0] v, input string req);
    hist[n] = v;
    dIn = v;
    @(posedge clk);
    n++;
    @(negedge clk);
    checkDepth(req, D_BIG, validBig, outBig);
    checkDepth(req, D_SMALL, validSmall, outSmall);
  endtask

  task automatic doReset(input int cycles, input string req);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      dIn = DW'(8'hC3 ^ i);
      @(posedge clk);
    end
    @(negedge clk);
    check({req, " big valid low"}, int'(validBig), 0);
    check({req, " big out zero"}, int'(outBig), 0);
    check({req, " small valid low"}, int'(validSmall), 0);
    check({req, " small out zero"}, int'(outSmall), 0);
    rst = 1'b0;
    n = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    doReset(3, "R1");

    // R2/R3/R5: counting sequence, several wraps of both depths
    for (int i = 0; i < 40; i++) begin
      step(DW'(i + 1), "count");
      if (n == D_BIG - 1) check("R3 big low before last", int'(validBig), 0);
      if (n == D_BIG)     check("R3 big rises", int'(validBig), 1);
    end

    // R8: bit patterns
    for (int i = 0; i < 16; i++) step('0, "R8 zeros");
    for (int i = 0; i < 16; i++) step('1, "R8 ones");
    for (int i = 0; i < 24; i++) step(DW'(1 << (i % DW)), "R8 walk");
    for (int i = 0; i < 24; i++) step((i % 2 == 0) ? 8'h55 : 8'hAA, "R8 alt");

    // R6: reset mid-stream, then a hashed sequence
    doReset(2, "R6");
    for (int i = 0; i < 60; i++) begin
      step(DW'((i * 37 + 11) ^ (i >> 2)), "R6 restart");
      if (n == D_SMALL - 1) check("R6 small low", int'(validSmall), 0);
      if (n == D_BIG - 1)   check("R6 big low", int'(validBig), 0);
    end

    // R6: a one-edge reset pulse
    doReset(1, "R6 short");
    for (int i = 0; i < 20; i++) step(DW'(8'hF0 - i), "R6 short");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule